// File: doc/BRIEF.md
# Channel Population Detector

This block runs once after every host reset and works out which of up to six terminal channels are fitted to the board, and whether a local processor sits on the local bus. The board marks a missing channel by tying that channel's interrupt line low. It marks a missing processor by tying the local-bus grant line low. The block holds all channels in master clear while reset is asserted and for a fixed number of clocks afterwards. It then waits a settle interval and captures the synchronised interrupt and grant levels in one clock edge. From that capture it reports a per-channel presence mask, a count of fitted channels and a processor-present flag.

The results sit in a read-only status word that the host register decode can return unchanged. The processor-present flag is also brought out on its own pin. Local-bus pad logic uses it to decide how the pins are driven: with a processor fitted they may float (tri-state); without one they are always driven (two-state). The results do not change until the next reset.

Host accesses to the channels pass through a valid/ready gate. Until detection is done, the gate holds both `chan_valid` and `host_ready` low, so no transfer can complete and the host sees back-pressure. Once detection is done the gate is transparent and carries no storage: `chan_valid` follows `host_valid` and `host_ready` follows `chan_ready` in the same cycle. A transfer completes in any cycle where `host_valid` and `host_ready` are both high.

Top module: `chan_presence_detect`

## Requirements
- R1: `mclr` is high while `rst_n` is low and stays high for exactly CLR_CYCLES (default 8) rising clock edges after `rst_n` is released; it then stays low until the next reset.
- R2: `det_done` goes high on the rising edge CLR_CYCLES+SETTLE_CYCLES (default 8+4=12) after reset release, and is low before that edge.
- R3: `status_word[5:0]` holds the presence mask. Bit i is 1 when `chan_irq[i]` was high at the capture, and 0 (channel not fitted) when it was low.
- R4: `status_word[8:6]` holds the number of 1 bits in the presence mask.
- R5: `cpu_present` and `status_word[9]` are 1 when `lb_grant` was high at the capture, and 0 (no local processor, local-bus pins driven two-state) when it was low.
- R6: `status_word[10]` mirrors `det_done`.
- R7: After `det_done` rises, `status_word` and `cpu_present` stay unchanged until the next reset, whatever `chan_irq` and `lb_grant` do.
- R8: While `det_done` is low, `chan_valid` and `host_ready` are both low, whatever `host_valid` and `chan_ready` are.
- R9: While `det_done` is high, `chan_valid` equals `host_valid` and `host_ready` equals `chan_ready` in the same cycle.
- R10: A reset asserted part-way through detection restarts the whole sequence, and the new capture reflects the inputs present during the new run.
- R11: While `rst_n` is low, `det_done` is 0 and `status_word` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Host reset, active low, asynchronous assert |
| chan_irq | input | 6 | Per-channel interrupt lines; a low level means the channel is not fitted |
| lb_grant | input | 1 | Local-bus grant; a low level means no local processor is fitted |
| mclr | output | 1 | Master clear to all channels, active high |
| det_done | output | 1 | Detection finished; results are valid |
| cpu_present | output | 1 | Latched local processor present flag |
| status_word | output | 11 | {done, cpu present, count[2:0], mask[5:0]} |
| host_valid | input | 1 | Host requests a channel access |
| host_ready | output | 1 | Access accepted toward the host |
| chan_valid | output | 1 | Access request toward the channels |
| chan_ready | input | 1 | Channels can accept the access |

## Verification
The case that is hardest to reach from the ports is a reset arriving part-way through detection. It must throw away the sequence already in progress and capture new strap levels, not keep the earlier ones. The stimulus reaches it by starting a run with one strap pattern and, before the run finishes, asserting reset with the complementary pattern. The capture must then show only the second pattern. Around that case, every one of the 64 mask patterns is combined with both grant levels. For each combination the bench tracks `mclr` and `det_done` edge by edge and computes the expected count arithmetically.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  // Detection phases, in the order they occur after reset release.
  typedef enum logic [1:0] {
    PH_CLEAR  = 2'd0,
    PH_SETTLE = 2'd1,
    PH_DONE   = 2'd2
  } phase_t;

  // Width needed to hold values 0..n.
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cpd_sync_bank.sv
module cpd_sync_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Each strap input gets its own two-stage synchroniser.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/cpd_sequencer.sv
module cpd_sequencer
  import cpd_pkg::*;
#(
  parameter int CLR_CYCLES    = 8,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mclr,
  output logic sample_en,
  output logic done
);
  localparam int MAXC = (CLR_CYCLES > SETTLE_CYCLES) ? CLR_CYCLES : SETTLE_CYCLES;
  localparam int CW   = width_for(MAXC);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYCLES - 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYCLES - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CLEAR;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      case (phase)
        PH_CLEAR: begin
          if (cnt == CLR_LAST) begin
            phase <= PH_SETTLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_SETTLE: begin
          if (cnt == SET_LAST) begin
            phase  <= PH_DONE;
            cnt    <= '0;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          phase <= PH_DONE;
        end
      endcase
    end
  end

  // Master clear is also held during reset, because the reset state is PH_CLEAR.
  assign mclr      = (phase == PH_CLEAR);
  assign sample_en = (phase == PH_SETTLE) && (cnt == SET_LAST);
  assign done      = done_q;
endmodule

// File: rtl/cpd_result_latch.sv
module cpd_result_latch #(
  parameter int NUM_CHAN = 6,
  parameter int CNT_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic [NUM_CHAN-1:0] irq_s,
  input  logic                gnt_s,
  output logic [NUM_CHAN-1:0] mask,
  output logic [CNT_W-1:0]    count,
  output logic                cpu
);
  logic [CNT_W-1:0] ones;

  // Population count of the synchronised strap levels.
  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_CHAN; i++) begin
      ones = ones + CNT_W'(irq_s[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask  <= '0;
      count <= '0;
      cpu   <= 1'b0;
    end else if (sample_en) begin
      mask  <= irq_s;
      count <= ones;
      cpu   <= gnt_s;
    end
  end
endmodule

// File: rtl/chan_presence_detect.sv
module chan_presence_detect
  import cpd_pkg::*;
#(
  parameter int NUM_CHAN      = 6,
  parameter int CLR_CYCLES    = 8,
  parameter int SETTLE_CYCLES = 4,
  localparam int CNT_W        = width_for(NUM_CHAN),
  localparam int STAT_W       = NUM_CHAN + CNT_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CHAN-1:0] chan_irq,
  input  logic                lb_grant,
  output logic                mclr,
  output logic                det_done,
  output logic                cpu_present,
  output logic [STAT_W-1:0]   status_word,
  input  logic                host_valid,
  output logic                host_ready,
  output logic                chan_valid,
  input  logic                chan_ready
);
  logic [NUM_CHAN:0]   raw_in;
  logic [NUM_CHAN:0]   sync_in;
  logic                sample_en;
  logic [NUM_CHAN-1:0] mask;
  logic [CNT_W-1:0]    count;

  // The grant line shares the synchroniser bank with the interrupt lines, in the top bit.
  assign raw_in = {lb_grant, chan_irq};

  cpd_sync_bank #(.W(NUM_CHAN + 1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  cpd_sequencer #(
    .CLR_CYCLES    (CLR_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (mclr),
    .sample_en (sample_en),
    .done      (det_done)
  );

  cpd_result_latch #(
    .NUM_CHAN (NUM_CHAN),
    .CNT_W    (CNT_W)
  ) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .irq_s     (sync_in[NUM_CHAN-1:0]),
    .gnt_s     (sync_in[NUM_CHAN]),
    .mask      (mask),
    .count     (count),
    .cpu       (cpu_present)
  );

  assign status_word = {det_done, cpu_present, count, mask};

  // Access gate: closed until detection finishes, transparent afterwards.
  assign chan_valid = host_valid & det_done;
  assign host_ready = chan_ready & det_done;
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
  parameter int NUM_CHAN   = 6,
  parameter int CLR_CYCLES = 8,
  parameter int CNT_W      = 3,
  parameter int STAT_W     = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mclr,
  input logic              det_done,
  input logic              cpu_present,
  input logic              chan_valid,
  input logic              host_ready,
  input logic [STAT_W-1:0] status_word
);
  // Counts clear-high cycles after reset release; checked in place of a long delay.
  logic [31:0] clr_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_run <= '0;
    else if (mclr) clr_run <= clr_run + 32'd1;
  end

  assert_clear_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclr) |-> clr_run == 32'(CLR_CYCLES));

  assert_clear_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_run <= 32'(CLR_CYCLES));

  assert_no_clear_when_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |-> !mclr);

  assert_count_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |-> status_word[NUM_CHAN+CNT_W-1:NUM_CHAN] ==
                 CNT_W'($countones(status_word[NUM_CHAN-1:0])));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(det_done) |-> det_done);

  assert_status_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(det_done) |-> $stable(status_word) && $stable(cpu_present));

  assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !det_done |-> !chan_valid && !host_ready);
endmodule

bind chan_presence_detect cpd_checker #(
  .NUM_CHAN   (NUM_CHAN),
  .CLR_CYCLES (CLR_CYCLES),
  .CNT_W      (CNT_W),
  .STAT_W     (STAT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mclr        (mclr),
  .det_done    (det_done),
  .cpu_present (cpu_present),
  .chan_valid  (chan_valid),
  .host_ready  (host_ready),
  .status_word (status_word)
);

// File: tb/sim_chan_presence_detect.sv
module sim_chan_presence_detect;
  localparam int NC = 6;
  localparam int MC = 8;
  localparam int SC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NC-1:0] irq = '0;
  logic        gnt = 1'b0;
  logic        hv = 1'b0;
  logic        cr = 1'b0;
  logic        mclr, done, cpu, cv, hr;
  logic [10:0] st;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  chan_presence_detect u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_irq    (irq),
    .lb_grant    (gnt),
    .mclr        (mclr),
    .det_done    (done),
    .cpu_present (cpu),
    .status_word (st),
    .host_valid  (hv),
    .host_ready  (hr),
    .chan_valid  (cv),
    .chan_ready  (cr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(input logic [NC-1:0] m);
    int n = 0;
    for (int i = 0; i < NC; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic run(input logic [NC-1:0] m, input logic g);
    int exp_st;
    @(negedge clk);
    rst_n = 1'b0; irq = m; gnt = g; hv = 1'b1; cr = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", "done in reset", int'(done), 0);
    chk("R11", "status in reset", int'(st), 0);
    chk("R1", "mclr in reset", int'(mclr), 1);
    chk("R8", "chan_valid in reset", int'(cv), 0);
    rst_n = 1'b1;
    for (int k = 1; k <= MC + SC; k++) begin
      @(negedge clk);
      chk("R1", "mclr after edge", int'(mclr), (k < MC) ? 1 : 0);
      chk("R2", "done after edge", int'(done), (k >= MC + SC) ? 1 : 0);
      if (k < MC + SC) begin
        chk("R8", "chan_valid held", int'(cv), 0);
        chk("R8", "host_ready held", int'(hr), 0);
      end
    end
    chk("R3", "mask", int'(st[5:0]), int'(m));
    chk("R4", "count", int'(st[8:6]), ones(m));
    chk("R5", "cpu pin", int'(cpu), int'(g));
    chk("R5", "cpu bit", int'(st[9]), int'(g));
    chk("R6", "done bit", int'(st[10]), 1);
    for (int c = 0; c < 4; c++) begin
      hv = c[0]; cr = c[1];
      #1;
      chk("R9", "chan_valid follows", int'(cv), c & 1);
      chk("R9", "host_ready follows", int'(hr), (c >> 1) & 1);
    end
    exp_st = (1 << 10) | (int'(g) << 9) | (ones(m) << 6) | int'(m);
    irq = ~m; gnt = ~g;
    repeat (4) @(negedge clk);
    chk("R7", "status after strap change", int'(st), exp_st);
    chk("R7", "cpu after strap change", int'(cpu), int'(g));
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int g = 0; g < 2; g++) begin
      for (int m = 0; m < (1 << NC); m++) begin
        run(NC'(m), g[0]);
      end
    end
    // R10: abort a run part-way with a reset carrying the opposite straps.
    @(negedge clk);
    rst_n = 1'b0; irq = 6'h15; gnt = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10", "not done mid-run", int'(done), 0);
    run(6'h2A, 1'b0);
    chk("R10", "mask after restart", int'(st[5:0]), 'h2A);
    chk("R10", "cpu after restart", int'(cpu), 0);
    finish_run();
  end
endmodule